// File: doc/BRIEF.md
# External Data Memory Bus Sequencer

This block runs the pin-level access cycle a small microcontroller core uses to reach byte-wide data memory outside the chip. The core hands it one request at a time: a read or a write, a 16-bit address and, for writes, one data byte. The block then steps a phase counter through twelve phases, T1 to T12. The counter advances once for each clock on which the phase enable input is high. While it counts, the block drives the strobes and sets the direction of a shared bus that carries the low address byte first and the data byte later.

On the pin side, the low address byte goes out on the multiplexed bus while the address latch enable is high, so an outside latch can capture it on the falling edge. The high address byte has its own pins. A read releases the bus for two turnaround phases before the active-low read strobe opens the device, and the data is taken on the last edge of T12. A write drives its data from T6 under the active-low write strobe. It keeps that data on the bus for a number of hold phases after T12, which covers the T1 and T2 that would follow. When a cycle ends, a one-clock done pulse is returned together with the read data.

The request side is a valid/ready port. Ready is high only when no cycle or write hold is in progress. A request transfers on a clock where both valid and ready are high. Until that clock, the requester must keep valid high and hold its fields steady. The response is a plain one-clock pulse and cannot be back-pressured.

Top module: `xmem_bus_seq`

## Requirements
- R1: `req_ready` is high exactly when the block is idle; a request with `req_valid` high on such a clock is taken, T1 begins on the next clock, and `req_valid` while not ready has no effect.
- R2: The phase counter leaves a phase only on a clock with `phase_en` high; every cycle spans exactly twelve phases; `rsp_valid` is high for the single clock after the enabled edge that ends T12, for reads and writes alike.
- R3: `ale` is high in T2, T3 and T4 and low at all other times.
- R4: In T1 to T4, `bus_oe` is 1 and `bus_out` equals `req_addr[7:0]`; in T1 to T12, `addr_hi` equals `req_addr[15:8]`.
- R5: In a read, `bus_oe` is 0 from T5 to T12, and `rd_n` is 0 in T7 to T12 and 1 otherwise.
- R6: After a read, `rsp_rdata` holds the value of `bus_in` at the enabled edge that ends T12, and it keeps that value until the next read completes.
- R7: In a write, `bus_oe` is 0 in T5; from T6 to T12, `bus_oe` is 1 and `bus_out` equals `req_wdata`; `wr_n` is 0 in T6 to T12 and 1 otherwise.
- R8: After the T12 of a write, the block stays in hold for `HOLD_PHASES` further phases (default 2). During hold, `bus_oe` is 1 with `bus_out` equal to the write data, `rd_n` and `wr_n` are 1, and `req_ready` is 0.
- R9: Outside a cycle and outside write hold (including right after reset), `rd_n` and `wr_n` are 1 and `bus_oe` and `ale` are 0.
- R10: `rd_n` and `wr_n` are never low together, and a completed write leaves `rsp_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_en | input | 1 | Phase advance enable |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-clock done pulse |
| rsp_rdata | output | 8 | Data from the last read |
| bus_out | output | 8 | Multiplexed address/data bus, outgoing value |
| bus_oe | output | 1 | Bus output enable |
| bus_in | input | 8 | Multiplexed bus, incoming value |
| addr_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The bench builds the block with its defaults: 16-bit address, 8-bit data and two write hold phases. With these values, every phase of a read, a write and the hold window that follows a write is a short run that the random stimulus crosses many times. A `phase_en` that is low on roughly a third of the clocks stretches phases to random lengths. It also puts a disabled clock inside T12, which tests whether read data is taken on the right edge. Requests that arrive during write hold and directly after a done pulse cover both sides of the ready rule.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  localparam int PH_W = 5;
  typedef logic [PH_W-1:0] phase_t;

  localparam phase_t PH_IDLE      = 5'd0;
  localparam phase_t PH_FIRST     = 5'd1;
  localparam phase_t PH_ALE_ON    = 5'd2;
  localparam phase_t PH_ADDR_LAST = 5'd4;
  localparam phase_t PH_WR_FIRST  = 5'd6;
  localparam phase_t PH_RD_FIRST  = 5'd7;
  localparam phase_t PH_LAST      = 5'd12;
endpackage

// File: rtl/xmem_phase_ctr.sv
module xmem_phase_ctr
  import xmem_pkg::*;
#(
  parameter int HOLD_PHASES = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   phase_en,
  input  logic   start,
  input  logic   is_write,
  output phase_t ph,
  output logic   last_edge
);
  localparam phase_t HOLD_END = phase_t'(int'(PH_LAST) + HOLD_PHASES);
  localparam bit     HAS_HOLD = (HOLD_PHASES > 0);

  assign last_edge = (ph == PH_LAST) && phase_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE;
    end else if (ph == PH_IDLE) begin
      if (start) ph <= PH_FIRST;
    end else if (phase_en) begin
      if (ph == PH_LAST)
        ph <= (is_write && HAS_HOLD) ? PH_LAST + 5'd1 : PH_IDLE;
      else if (ph == HOLD_END)
        ph <= PH_IDLE;
      else
        ph <= ph + 5'd1;
    end
  end
endmodule

// File: rtl/xmem_req_regs.sv
module xmem_req_regs #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              wr_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              cap,
  input  logic [DATA_W-1:0] bus_in,
  output logic              is_write,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rsp_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_write  <= 1'b0;
      addr      <= '0;
      wdata     <= '0;
      rdata     <= '0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= cap;
      if (load) begin
        is_write <= wr_in;
        addr     <= addr_in;
        wdata    <= wdata_in;
      end
      if (cap && !is_write) rdata <= bus_in;
    end
  end
endmodule

// File: rtl/xmem_pin_decode.sv
module xmem_pin_decode
  import xmem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  phase_t                   ph,
  input  logic                     is_write,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        bus_out,
  output logic                     bus_oe,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n
);
  logic addr_ph, rd_ph, wr_ph, hold_ph;

  always_comb begin
    addr_ph = (ph >= PH_FIRST) && (ph <= PH_ADDR_LAST);
    rd_ph   = !is_write && (ph >= PH_RD_FIRST) && (ph <= PH_LAST);
    wr_ph   = is_write && (ph >= PH_WR_FIRST) && (ph <= PH_LAST);
    hold_ph = (ph > PH_LAST);

    ale     = (ph >= PH_ALE_ON) && (ph <= PH_ADDR_LAST);
    rd_n    = !rd_ph;
    wr_n    = !wr_ph;
    bus_oe  = addr_ph || wr_ph || hold_ph;
    addr_hi = addr[ADDR_W-1:DATA_W];
    if (addr_ph)              bus_out = addr[DATA_W-1:0];
    else if (wr_ph || hold_ph) bus_out = wdata;
    else                      bus_out = '0;
  end
endmodule

// File: rtl/xmem_bus_seq.sv
module xmem_bus_seq
  import xmem_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int HOLD_PHASES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     phase_en,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [DATA_W-1:0]        bus_out,
  output logic                     bus_oe,
  input  logic [DATA_W-1:0]        bus_in,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n
);
  phase_t            ph;
  logic              last_edge;
  logic              start;
  logic              is_write;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign req_ready = (ph == PH_IDLE);
  assign start     = req_valid && req_ready;

  xmem_phase_ctr #(.HOLD_PHASES(HOLD_PHASES)) u_ctr (
    .clk(clk), .rst_n(rst_n), .phase_en(phase_en), .start(start),
    .is_write(is_write), .ph(ph), .last_edge(last_edge)
  );

  xmem_req_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .load(start), .wr_in(req_write),
    .addr_in(req_addr), .wdata_in(req_wdata), .cap(last_edge),
    .bus_in(bus_in), .is_write(is_write), .addr(addr_q),
    .wdata(wdata_q), .rdata(rsp_rdata), .rsp_valid(rsp_valid)
  );

  xmem_pin_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .ph(ph), .is_write(is_write), .addr(addr_q), .wdata(wdata_q),
    .bus_out(bus_out), .bus_oe(bus_oe), .addr_hi(addr_hi),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
  );
endmodule

// File: rtl/xmem_bus_seq_chk.sv
module xmem_bus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic phase_en,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_valid,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic bus_oe
);
  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R3
  ale_quiet_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n));

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R5
  rd_bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !bus_oe);

  // R7
  wr_bus_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> bus_oe);

  // R2
  stall_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_en |=> ($stable(ale) && $stable(rd_n) && $stable(wr_n)));
endmodule

bind xmem_bus_seq xmem_bus_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .phase_en(phase_en), .req_valid(req_valid),
  .req_ready(req_ready), .rsp_valid(rsp_valid), .ale(ale),
  .rd_n(rd_n), .wr_n(wr_n), .bus_oe(bus_oe)
);

// File: tb/xmem_bus_seq_tb.sv
`timescale 1ns/1ps
module xmem_bus_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phase_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  bus_in = '0;
  logic        req_ready, rsp_valid, bus_oe, ale, rd_n, wr_n;
  logic [7:0]  rsp_rdata, bus_out, addr_hi;

  int checks = 0;
  int errors = 0;
  bit done_run = 0;

  int          mp = 0;
  bit          mw = 0;
  logic [15:0] ma = '0;
  logic [7:0]  md = '0;
  logic [7:0]  mrd = '0;
  bit          mrsp = 0;

  always #4 clk = ~clk;

  xmem_bus_seq u_dut (
    .clk(clk), .rst_n(rst_n), .phase_en(phase_en), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in), .addr_hi(addr_hi),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
  );

  function automatic bit in_rng(int p, int lo, int hi);
    return (p >= lo) && (p <= hi);
  endfunction
  function automatic bit e_ale(int p);
    return in_rng(p, 2, 4);
  endfunction
  function automatic bit e_oe(int p, bit w);
    return in_rng(p, 1, 4) || (w && in_rng(p, 6, 12)) || (p > 12);
  endfunction
  function automatic bit e_rd_n(int p, bit w);
    return !(!w && in_rng(p, 7, 12));
  endfunction
  function automatic bit e_wr_n(int p, bit w);
    return !(w && in_rng(p, 6, 12));
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h phase=%0d", tag, act, exp, mp);
    end
  endtask

  task automatic check_outputs();
    chk("R1 req_ready", 16'(req_ready), 16'(mp == 0));
    chk("R2 rsp_valid", 16'(rsp_valid), 16'(mrsp));
    chk("R3 ale", 16'(ale), 16'(e_ale(mp)));
    chk("R5/R7/R8/R9 bus_oe", 16'(bus_oe), 16'(e_oe(mp, mw)));
    chk("R5/R9 rd_n", 16'(rd_n), 16'(e_rd_n(mp, mw)));
    chk("R7/R9 wr_n", 16'(wr_n), 16'(e_wr_n(mp, mw)));
    chk("R6/R10 rsp_rdata", 16'(rsp_rdata), 16'(mrd));
    if (in_rng(mp, 1, 4)) chk("R4 bus_out addr", 16'(bus_out), 16'(ma[7:0]));
    if (in_rng(mp, 1, 12)) chk("R4 addr_hi", 16'(addr_hi), 16'(ma[15:8]));
    if (mw && mp >= 6) chk("R7/R8 bus_out data", 16'(bus_out), 16'(md));
  endtask

  task automatic step(input bit en, input bit v, input bit w,
                      input logic [15:0] a, input logic [7:0] d, input logic [7:0] b);
    int old;
    @(negedge clk);
    check_outputs();
    phase_en = en; req_valid = v; req_write = w;
    req_addr = a; req_wdata = d; bus_in = b;
    old = mp;
    mrsp = (old == 12) && en;
    if (old == 0) begin
      if (v) begin mp = 1; mw = w; ma = a; md = d; end
    end else if (en) begin
      if (old == 12) begin
        if (!mw) mrd = b;
        mp = mw ? 13 : 0;
      end else if (old == 14) mp = 0;
      else mp = old + 1;
    end
  endtask

  initial begin
    void'($urandom(32'd20251));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state
    step(1, 0, 0, 16'h0, 8'h0, 8'h0);
    step(1, 0, 0, 16'h0, 8'h0, 8'h0);
    // R5 R6: directed read, enable always high
    step(1, 1, 0, 16'hA55A, 8'h00, 8'h11);
    for (int i = 0; i < 13; i++) step(1, 0, 0, 16'h0, 8'h0, 8'(8'h30 + i));
    // R7 R8 R1: write, then request during hold
    step(1, 1, 1, 16'h3C81, 8'hE7, 8'h00);
    for (int i = 0; i < 12; i++) step(1, 0, 0, 16'h0, 8'h0, 8'h5A);
    for (int i = 0; i < 4; i++) step(1, 1, 0, 16'h1234, 8'h00, 8'hC3);
    for (int i = 0; i < 14; i++) step(i % 2 == 0, 0, 0, 16'h0, 8'h0, 8'(i));
    // R2 R6: random enable gaps, random requests and bus values
    for (int i = 0; i < 6000; i++) begin
      logic [15:0] a;
      a = 16'($urandom);
      step(($urandom % 3) != 0, ($urandom % 4) == 0, $urandom % 2,
           a, 8'($urandom), 8'($urandom));
    end
    step(1, 0, 0, 16'h0, 8'h0, 8'h0);
    done_run = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_run) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule